// File: doc/BRIEF.md
# Serial Debug-Mux Scan Reader

This block reads a bank of single-bit debug signals from a target machine, one bit at a time, through a narrow output word and a single input data bit. The target keeps an 11-bit selector in a serial shift register that advances on the falling edge of a strobe line. The reader clocks a selector into that register, waits for the selected signal to settle, samples it, and packs the result into a 128-word by 16-bit result memory. The memory must be cleared before a scan begins.

The selector does not step through a counter. It advances by an in-place linear-feedback step: the current value moves left by one, its top bit is dropped, and a new low bit is formed from two fixed selector bits. Starting from zero, the scan visits every selector value except all-ones, and it finishes when the selector comes back to zero. Only one new bit then has to be shifted per signal, so the target register never needs a full reload during a scan.

A host starts a scan with a start pulse and a starting selector. It may stop the scan at any time with an abort pulse. After an abort, the block reports the selector it was working on, and a later start from that value finishes the remaining signals.

Top module: `dmux_scan_reader`

## Requirements
- R1: While idle, `out_word` equals `clk_bits` with bit 15 (selector bit) and bit 6 (strobe) forced to 0, and `busy` is low.
- R2: Each selector bit is presented on `out_word` bit 15 for three consecutive cycles. The strobe, `out_word` bit 6, is low in the first cycle, high in the second and low in the third.
- R3: After a start, the block shifts four zero bits and then all 11 bits of `start_addr`, most significant first (15 strobes), before it takes the first sample. Each later signal costs exactly one more strobe.
- R4: The selector after address a is {a[9:0], a[10] XNOR a[8]}. A scan from 0 samples every address except 2047, and it ends after it samples the address whose successor is 0.
- R5: `tgt_bit` is sampled on the clock edge that comes SETTLE edges after the edge that ends the strobe-low cycle following the strobe.
- R6: The sample for address a goes to memory word a[10:4], at bit 15 − a[3:0], so position 0 is the word's most significant bit.
- R7: A sampled 0 causes no memory access. A sampled 1 raises `mem_re` for one cycle. In the next cycle, `mem_we` writes back to the same word the read data OR the bit mask of R6. Read data arrives one cycle after `mem_re`.
- R8: At normal completion, `done` is high for exactly one cycle, `resume_addr` reads 0, and `busy` is low.
- R9: An abort while busy makes the block idle at the next edge, with bit 15 and the strobe low, and `resume_addr` holds the address being processed. A new start from `resume_addr` fills in every remaining bit.
- R10: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan from `start_addr` (taken only when idle) |
| abort | input | 1 | Stop a running scan |
| start_addr | input | 11 | First selector value of the scan |
| clk_bits | input | 16 | Base control word placed on the output port |
| out_word | output | 16 | Output port word to the target |
| tgt_bit | input | 1 | Data bit returned by the target |
| mem_addr | output | 7 | Result memory word address |
| mem_re | output | 1 | Result memory read enable |
| mem_rdata | input | 16 | Result memory read data (one-cycle latency) |
| mem_we | output | 1 | Result memory write enable |
| mem_wdata | output | 16 | Result memory write data |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| resume_addr | output | 11 | Address to resume from after an abort, 0 after completion |

## Verification
A wrong feedback tap or a wrong shift count shows up within the first few hundred cycles. The target's shift register then drifts from the selector the reader believes it holds, so later bits land in the wrong memory positions, and the scan either ends early or never returns to zero. A bad settle count or a bad bit-to-position mapping shows up only when the packed memory is compared word by word against the random pattern after `done`. A broken read-modify-write drops neighbouring bits in the same word at the next one-bit sample.

// File: rtl/dmux_scan_reader.sv
module dmux_scan_reader #(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int PAD = 4,
  parameter int SETTLE = 6,
  parameter int STB_BIT = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          abort,
  input  logic [AW-1:0]                 start_addr,
  input  logic [DW-1:0]                 clk_bits,
  output logic [DW-1:0]                 out_word,
  input  logic                          tgt_bit,
  output logic [AW-$clog2(DW)-1:0]      mem_addr,
  output logic                          mem_re,
  input  logic [DW-1:0]                 mem_rdata,
  output logic                          mem_we,
  output logic [DW-1:0]                 mem_wdata,
  output logic                          busy,
  output logic                          done,
  output logic [AW-1:0]                 resume_addr
);
  localparam int BW = $clog2(DW);
  localparam int SW = PAD + AW;
  localparam int CW = $clog2(SW + 1);
  localparam int WW = $clog2(SETTLE + 1);
  localparam int ABIT = DW - 1;
  localparam int TAP_A = AW - 1;
  localparam int TAP_B = AW - 3;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_WAIT, S_RD, S_WR, S_ADV} st_t;

  st_t           state;
  logic [AW-1:0] cur;
  logic [SW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [WW-1:0] wcnt;
  logic [AW-1:0] nxt;
  logic          abit, stb;
  logic [DW-1:0] keep_mask, pos_mask;

  assign nxt       = {cur[AW-2:0], cur[TAP_A] ~^ cur[TAP_B]};
  assign abit      = (state == S_SHIFT) && sh[SW-1];
  assign stb       = (state == S_SHIFT) && (ph == 2'd1);
  assign keep_mask = ~((DW'(1) << ABIT) | (DW'(1) << STB_BIT));
  assign out_word  = (clk_bits & keep_mask) | (DW'(abit) << ABIT) | (DW'(stb) << STB_BIT);
  assign pos_mask  = {1'b1, {(DW-1){1'b0}}} >> cur[BW-1:0];
  assign mem_addr  = cur[AW-1:BW];
  assign mem_re    = (state == S_RD);
  assign mem_we    = (state == S_WR);
  assign mem_wdata = mem_rdata | pos_mask;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cur         <= '0;
      sh          <= '0;
      cnt         <= '0;
      ph          <= '0;
      wcnt        <= '0;
      done        <= 1'b0;
      resume_addr <= '0;
    end else begin
      done <= 1'b0;
      if (state != S_IDLE && abort) begin
        state       <= S_IDLE;
        resume_addr <= cur;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            cur   <= start_addr;
            sh    <= {{PAD{1'b0}}, start_addr};
            cnt   <= CW'(SW);
            ph    <= '0;
            state <= S_SHIFT;
          end
          S_SHIFT: begin
            if (ph == 2'd2) begin
              ph <= '0;
              if (cnt == CW'(1)) begin
                wcnt  <= WW'(SETTLE - 1);
                state <= S_WAIT;
              end else begin
                cnt <= cnt - CW'(1);
                sh  <= {sh[SW-2:0], 1'b0};
              end
            end else begin
              ph <= ph + 2'd1;
            end
          end
          S_WAIT: begin
            if (wcnt == '0) state <= tgt_bit ? S_RD : S_ADV;
            else            wcnt  <= wcnt - WW'(1);
          end
          S_RD: state <= S_WR;
          S_WR: state <= S_ADV;
          S_ADV: begin
            if (nxt == '0) begin
              state       <= S_IDLE;
              done        <= 1'b1;
              resume_addr <= '0;
            end else begin
              cur   <= nxt;
              sh    <= {nxt[0], {(SW-1){1'b0}}};
              cnt   <= CW'(1);
              ph    <= '0;
              state <= S_SHIFT;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmux_scan_reader_chk.sv
module dmux_scan_reader_chk #(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int STB_BIT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] out_word,
  input logic          mem_re,
  input logic          mem_we,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] mem_wdata,
  input logic [AW-$clog2(DW)-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] resume_addr
);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_word[STB_BIT]) |=> !out_word[STB_BIT]);
  a_r2_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_word[STB_BIT] |=> $stable(out_word[DW-1]));
  a_r2_bit_setup: assert property (@(posedge clk) disable iff (!rst_n)
    out_word[STB_BIT] |-> $stable(out_word[DW-1]));
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_re) && mem_addr == $past(mem_addr)));
  a_r7_single_bit_merge: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (((mem_wdata & mem_rdata) == mem_rdata) && $countones(mem_wdata ^ mem_rdata) <= 1));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && resume_addr == '0));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_word[DW-1] && !out_word[STB_BIT] && !mem_re && !mem_we));
endmodule

bind dmux_scan_reader dmux_scan_reader_chk #(.AW(AW), .DW(DW), .STB_BIT(STB_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_word(out_word), .mem_re(mem_re), .mem_we(mem_we),
  .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_addr(mem_addr), .busy(busy),
  .done(done), .resume_addr(resume_addr));

// File: tb/tb_dmux_scan_reader.sv
module tb_dmux_scan_reader;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0;
  logic [10:0] start_addr = '0;
  logic [15:0] clk_bits = '0;
  logic [15:0] out_word;
  logic        tgt_bit;
  logic [6:0]  mem_addr;
  logic        mem_re, mem_we, busy, done;
  logic [15:0] mem_rdata, mem_wdata;
  logic [10:0] resume_addr;

  int total = 0, bad = 0, cycles = 0;
  int falls = 0, writes = 0, long_stb = 0;

  logic [NBITS-1:0] pat;
  logic [15:0] mem [128];
  logic [15:0] rdq = '0;
  logic [10:0] treg = '0;
  int          age = 0;
  logic        prev_stb = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmux_scan_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .start_addr(start_addr),
    .clk_bits(clk_bits), .out_word(out_word), .tgt_bit(tgt_bit), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .resume_addr(resume_addr));

  assign mem_rdata = rdq;
  assign tgt_bit   = (age >= 4) ? pat[treg] : ~pat[treg];

  always @(posedge clk) begin
    if (mem_re) rdq <= mem[mem_addr];
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      writes++;
    end
    if (prev_stb && out_word[6]) long_stb++;
    if (prev_stb && !out_word[6]) begin
      treg <= {treg[9:0], out_word[15]};
      age  <= 0;
      falls++;
    end else if (age < 15) begin
      age <= age + 1;
    end
    prev_stb <= out_word[6];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) mem[i] = '0;
  endtask

  task automatic fill_pat(input int kind);
    for (int i = 0; i < NBITS; i++) pat[i] = (kind == 0) ? 1'b0 : 1'($urandom);
    pat[NBITS-1] = 1'b1;
  endtask

  task automatic pulse_start(input logic [10:0] a);
    @(negedge clk); start_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output int ok);
    ok = 0;
    for (int n = 0; n < 60000; n++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic compare_mem(input string req);
    for (int w = 0; w < 128; w++) begin
      logic [15:0] e;
      for (int j = 0; j < 16; j++) begin
        int idx;
        idx = w * 16 + j;
        e[15-j] = (idx == NBITS - 1) ? 1'b0 : pat[idx];
      end
      check(req, {16'h0, mem[w]}, {16'h0, e});
    end
  endtask

  function automatic int ones_expected();
    int c = 0;
    for (int i = 0; i < NBITS - 1; i++) c += int'(pat[i]);
    return c;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset busy", 32'(busy), 0);
    check("R8 reset done", 32'(done), 0);
    check("R9 reset resume", 32'(resume_addr), 0);
    check("R1 reset out", 32'(out_word), 0);
  endtask

  task automatic t_idle_mask();
    @(negedge clk); clk_bits = 16'hFFFF;
    #1 check("R1 idle mask all ones", 32'(out_word), 32'h7FBF);
    clk_bits = 16'h1234;
    #1 check("R1 idle pass-through", 32'(out_word), 32'h1234);
  endtask

  task automatic t_full_scan();
    int ok;
    fill_pat(1); clear_mem();
    falls = 0; writes = 0; long_stb = 0;
    pulse_start(11'd0);
    check("R1 busy after start", 32'(busy), 1);
    repeat (3000) @(negedge clk);
    pulse_start(11'd5);
    wait_done(ok);
    check("R8 done seen", 32'(ok), 1);
    check("R8 resume zero at done", 32'(resume_addr), 0);
    @(negedge clk);
    check("R8 done one cycle", 32'(done), 0);
    check("R8 idle after done", 32'(busy), 0);
    check("R3 R4 R10 strobe count", 32'(falls), 32'(15 + 2046));
    check("R2 strobe width", 32'(long_stb), 0);
    check("R7 write count", 32'(writes), 32'(ones_expected()));
    compare_mem("R4 R5 R6 R7 memory");
  endtask

  task automatic t_zero_scan();
    int ok;
    fill_pat(0); clear_mem();
    writes = 0;
    pulse_start(11'd0);
    wait_done(ok);
    check("R8 zero-pattern done", 32'(ok), 1);
    check("R7 no writes on zero data", 32'(writes), 0);
    compare_mem("R7 memory untouched");
  endtask

  task automatic t_abort_resume();
    int ok;
    logic [10:0] r;
    fill_pat(1); clear_mem();
    pulse_start(11'd0);
    repeat (7001) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    check("R9 idle after abort", 32'(busy), 0);
    check("R9 outputs quiet", 32'({out_word[15], out_word[6]}), 0);
    check("R9 no done on abort", 32'(done), 0);
    r = resume_addr;
    check("R9 resume nonzero", 32'(r != 0), 1);
    repeat (20) @(negedge clk);
    check("R9 still idle", 32'(busy), 0);
    pulse_start(r);
    wait_done(ok);
    check("R9 resumed scan done", 32'(ok), 1);
    compare_mem("R9 memory after resume");
  endtask

  initial begin
    void'($urandom(32'd77));
    clear_mem();
    pat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_mask();
    t_full_scan();
    t_zero_scan();
    t_abort_resume();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule